// File: doc/BRIEF.md
# Clock System Controller with Low-Power Gating

This block turns oscillator strobes into three divided clock enables: a main enable, a sub-main enable and an auxiliary enable. Each oscillator is seen as a one-cycle strobe on the system clock. The strobes are a digitally controlled oscillator, a second crystal, a very-low-power oscillator and a low-frequency crystal. Software uses a simple byte bus to program four 8-bit registers. One system control register picks the main and sub-main sources and their dividers. The other holds the auxiliary divider. The oscillator control and auxiliary control registers are held and can be read back.

The processor's four power status bits feed a small power-mode state machine. Its states are ACT, L0, L1, L2, L3, L4 and BAD. On every cycle the state moves to the state decoded from the bits, so any state can go to any other. The state chooses which enables may run. Each channel has a free-running divider. The channel accepts a new source or gate value only when its divider wraps, so a changed setting never cuts a period short. A change in a channel's divider code restarts that divider from zero.

Top module: `clksys_ctrl`

## Requirements
- R1: After reset, reading address 0x56 gives 0x60, 0x57 gives 0x87, 0x58 gives 0x00 and 0x53 gives 0x05. Any other address reads 0x00, and all three enables stay low while no strobe arrives.
- R2: A write to one of the four mapped addresses updates that register on the next clock edge. A write to any other address changes no register.
- R3: The main source comes from bits 7:6 of register 0x58. Codes 00 and 01 pick the oscillator strobe, 10 picks the crystal strobe and 11 picks the very-low-power strobe.
- R4: The main divider code sits in bits 5:4 of 0x58. Codes 00, 01, 10 and 11 give one enable pulse per 1, 2, 4 or 8 source strobes.
- R5: The sub-main source is bit 3 of 0x58, with 0 for the oscillator strobe and 1 for the crystal strobe. Its divider code sits in bits 2:1 and uses the same 1/2/4/8 encoding.
- R6: The auxiliary enable always counts the low-frequency strobe. Its divider code sits in bits 5:4 of 0x57 and uses the same encoding.
- R7: With the power bits {gen1,gen0,osc,cpu} at 0000 (ACT), all three enables run. At 0001 (L0) the main enable stops, and the sub-main and auxiliary enables run.
- R8: At 0101 (L1) the main enable stops, and the sub-main and auxiliary enables run. At 1001 (L2) and 1101 (L3) only the auxiliary enable runs.
- R9: At 1111 (L4) all enables stop. Every combination not named in R7 or R8 (BAD) also stops all enables.
- R10: A write that changes a channel's divider code restarts that channel's counter. With a strobe on every cycle and divide-by-N, the first pulse comes exactly N edges after the write edge, and no shorter period appears.
- R11: A power-mode or source change takes effect only at the channel's next divider wrap. The enable pulse at that wrap still uses the old gate. Each enable pulse follows a strobe of the channel's source on the edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Combinational read data |
| pw_cpu_off | input | 1 | Processor-off status bit |
| pw_osc_off | input | 1 | Oscillator-off status bit |
| pw_gen0_off | input | 1 | First clock-generator-off status bit |
| pw_gen1_off | input | 1 | Second clock-generator-off status bit |
| dco_tick | input | 1 | Controlled-oscillator strobe |
| xt2_tick | input | 1 | Second crystal strobe |
| vlo_tick | input | 1 | Very-low-power oscillator strobe |
| lf_tick | input | 1 | Low-frequency crystal strobe |
| main_en | output | 1 | Main clock enable |
| sub_en | output | 1 | Sub-main clock enable |
| aux_en | output | 1 | Auxiliary clock enable |

## Verification
The bench builds the block with its default parameters: 8-bit addresses and 2-bit divider codes, so the largest divide is eight. At these values every divider code can be used on every source within short windows. The strobe periods are 1, 2, 3 and 6 cycles, so each window holds a whole number of periods for every divide. Pulse counts therefore do not depend on divider phase. A known restart point lets the bench place one power change exactly between two divider wraps.

// File: rtl/clksys_pkg.sv
package clksys_pkg;

    typedef enum logic [2:0] {
        PM_ACT, PM_L0, PM_L1, PM_L2, PM_L3, PM_L4, PM_BAD
    } pmode_e;

    localparam int NSRC    = 4;
    localparam int SRC_DCO = 0;
    localparam int SRC_XT2 = 1;
    localparam int SRC_VLO = 2;
    localparam int SRC_LF  = 3;
    localparam int NCHAN   = 3;

    function automatic pmode_e pm_decode(input logic cpu, input logic osc,
                                         input logic g0, input logic g1);
        unique case ({g1, g0, osc, cpu})
            4'b0000: return PM_ACT;
            4'b0001: return PM_L0;
            4'b0101: return PM_L1;
            4'b1001: return PM_L2;
            4'b1101: return PM_L3;
            4'b1111: return PM_L4;
            default: return PM_BAD;
        endcase
    endfunction

endpackage

// File: rtl/clksys_regs.sv
module clksys_regs #(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 2,
    parameter logic [ADDR_W-1:0] A_OSC  = 'h56,
    parameter logic [ADDR_W-1:0] A_SYS1 = 'h57,
    parameter logic [ADDR_W-1:0] A_SYS2 = 'h58,
    parameter logic [ADDR_W-1:0] A_AUXC = 'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [1:0]        main_src,
    output logic [CODE_W-1:0] main_code,
    output logic              sub_src,
    output logic [CODE_W-1:0] sub_code,
    output logic [CODE_W-1:0] aux_code,
    output logic              rs_main,
    output logic              rs_sub,
    output logic              rs_aux
);
    logic [7:0] osc_q, sys1_q, sys2_q, auxc_q;
    logic       hit;

    assign hit = (wr_addr == A_OSC) || (wr_addr == A_SYS1) ||
                 (wr_addr == A_SYS2) || (wr_addr == A_AUXC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q  <= 8'h60;
            sys1_q <= 8'h87;
            sys2_q <= 8'h00;
            auxc_q <= 8'h05;
        end else if (wr_en) begin
            if (wr_addr == A_OSC)  osc_q  <= wr_data;
            if (wr_addr == A_SYS1) sys1_q <= wr_data;
            if (wr_addr == A_SYS2) sys2_q <= wr_data;
            if (wr_addr == A_AUXC) auxc_q <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr == A_OSC)       rd_data = osc_q;
        else if (rd_addr == A_SYS1) rd_data = sys1_q;
        else if (rd_addr == A_SYS2) rd_data = sys2_q;
        else if (rd_addr == A_AUXC) rd_data = auxc_q;
        else                        rd_data = 8'h00;
    end

    assign main_src  = sys2_q[7:6];
    assign main_code = sys2_q[4 +: CODE_W];
    assign sub_src   = sys2_q[3];
    assign sub_code  = sys2_q[1 +: CODE_W];
    assign aux_code  = sys1_q[4 +: CODE_W];

    assign rs_main = wr_en && (wr_addr == A_SYS2) && (wr_data[4 +: CODE_W] != main_code);
    assign rs_sub  = wr_en && (wr_addr == A_SYS2) && (wr_data[1 +: CODE_W] != sub_code);
    assign rs_aux  = wr_en && (wr_addr == A_SYS1) && (wr_data[4 +: CODE_W] != aux_code);

    p_unmapped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable({osc_q, sys1_q, sys2_q, auxc_q}));

endmodule

// File: rtl/clksys_pmode.sv
module clksys_pmode
    import clksys_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_off,
    input  logic osc_off,
    input  logic gen0_off,
    input  logic gen1_off,
    output logic gate_main,
    output logic gate_sub,
    output logic gate_aux
);
    pmode_e state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_ACT;
        else        state_q <= pm_decode(cpu_off, osc_off, gen0_off, gen1_off);
    end

    always_comb begin
        unique case (state_q)
            PM_ACT:        {gate_main, gate_sub, gate_aux} = 3'b111;
            PM_L0, PM_L1:  {gate_main, gate_sub, gate_aux} = 3'b011;
            PM_L2, PM_L3:  {gate_main, gate_sub, gate_aux} = 3'b001;
            default:       {gate_main, gate_sub, gate_aux} = 3'b000;
        endcase
    end

    p_l4_from_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_L4) |-> $past(cpu_off && osc_off && gen0_off && gen1_off));

    p_act_from_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && gate_main) |-> $past(!cpu_off && !osc_off && !gen0_off && !gen1_off));

endmodule

// File: rtl/clksys_chan.sv
module clksys_chan #(
    parameter int NSRC    = 4,
    parameter int CODE_W  = 2,
    parameter int SEL_W   = $clog2(NSRC),
    parameter int RST_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CODE_W-1:0] div_code,
    input  logic              restart,
    input  logic              gate_req,
    output logic              en
);
    localparam int MAXDIV = 1 << ((1 << CODE_W) - 1);
    localparam int CNT_W  = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

    logic [CNT_W-1:0] cnt_q, lim;
    logic [SEL_W-1:0] sel_q;
    logic             gate_q, tick;

    assign lim  = (CNT_W'(1) << div_code) - CNT_W'(1);
    assign tick = src_tick[sel_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            en     <= 1'b0;
            sel_q  <= SEL_W'(RST_SEL);
            gate_q <= 1'b1;
        end else if (restart) begin
            cnt_q <= '0;
            en    <= 1'b0;
        end else if (tick) begin
            if (cnt_q == lim) begin
                cnt_q  <= '0;
                en     <= gate_q;
                sel_q  <= sel;
                gate_q <= gate_req;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                en    <= 1'b0;
            end
        end else begin
            en <= 1'b0;
        end
    end

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !en);

    p_en_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $past(tick));

endmodule

// File: rtl/clksys_ctrl.sv
module clksys_ctrl
    import clksys_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              pw_cpu_off,
    input  logic              pw_osc_off,
    input  logic              pw_gen0_off,
    input  logic              pw_gen1_off,
    input  logic              dco_tick,
    input  logic              xt2_tick,
    input  logic              vlo_tick,
    input  logic              lf_tick,
    output logic              main_en,
    output logic              sub_en,
    output logic              aux_en
);
    localparam int SEL_W = $clog2(NSRC);

    logic [1:0]        main_src;
    logic              sub_src;
    logic [CODE_W-1:0] ch_code [NCHAN];
    logic [SEL_W-1:0]  ch_sel  [NCHAN];
    logic [NCHAN-1:0]  ch_rs, ch_gate, ch_en;
    logic [NSRC-1:0]   ticks;

    assign ticks = {lf_tick, vlo_tick, xt2_tick, dco_tick};

    clksys_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .main_src(main_src), .main_code(ch_code[0]), .sub_src(sub_src),
        .sub_code(ch_code[1]), .aux_code(ch_code[2]),
        .rs_main(ch_rs[0]), .rs_sub(ch_rs[1]), .rs_aux(ch_rs[2])
    );

    clksys_pmode u_pmode (
        .clk(clk), .rst_n(rst_n), .cpu_off(pw_cpu_off), .osc_off(pw_osc_off),
        .gen0_off(pw_gen0_off), .gen1_off(pw_gen1_off),
        .gate_main(ch_gate[0]), .gate_sub(ch_gate[1]), .gate_aux(ch_gate[2])
    );

    always_comb begin
        if (!main_src[1])     ch_sel[0] = SEL_W'(SRC_DCO);
        else if (main_src[0]) ch_sel[0] = SEL_W'(SRC_VLO);
        else                  ch_sel[0] = SEL_W'(SRC_XT2);
        ch_sel[1] = sub_src ? SEL_W'(SRC_XT2) : SEL_W'(SRC_DCO);
        ch_sel[2] = SEL_W'(SRC_LF);
    end

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        clksys_chan #(
            .NSRC(NSRC), .CODE_W(CODE_W), .SEL_W(SEL_W),
            .RST_SEL((g == 2) ? SRC_LF : SRC_DCO)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .src_tick(ticks), .sel(ch_sel[g]),
            .div_code(ch_code[g]), .restart(ch_rs[g]), .gate_req(ch_gate[g]),
            .en(ch_en[g])
        );
    end

    assign main_en = ch_en[0];
    assign sub_en  = ch_en[1];
    assign aux_en  = ch_en[2];

    p_main_src_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        main_en |-> $past(dco_tick || xt2_tick || vlo_tick));

    p_sub_src_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> $past(dco_tick || xt2_tick));

    p_aux_lf_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aux_en |-> $past(lf_tick));

endmodule

// File: tb/clksys_ctrl_tb.sv
module clksys_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       pw_cpu_off = 0, pw_osc_off = 0, pw_gen0_off = 0, pw_gen1_off = 0;
    logic       dco_tick = 0, xt2_tick = 0, vlo_tick = 0, lf_tick = 0;
    logic       main_en, sub_en, aux_en;
    int         n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    clksys_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pw_cpu_off(pw_cpu_off), .pw_osc_off(pw_osc_off),
        .pw_gen0_off(pw_gen0_off), .pw_gen1_off(pw_gen1_off),
        .dco_tick(dco_tick), .xt2_tick(xt2_tick), .vlo_tick(vlo_tick),
        .lf_tick(lf_tick), .main_en(main_en), .sub_en(sub_en), .aux_en(aux_en)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int i);
        dco_tick = 1'b1;
        xt2_tick = (i % 2) == 0;
        vlo_tick = (i % 3) == 0;
        lf_tick  = (i % 6) == 0;
    endtask

    task automatic quiet();
        {dco_tick, xt2_tick, vlo_tick, lf_tick} = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        rd_addr = a; #1;
        chk(int'(rd_data), exp, tag);
    endtask

    function automatic int expc(input int per, input int div, input bit on);
        return on ? (48 / per) / div : 0;
    endfunction

    task automatic measure(input int em, input int es, input int ea, input string tag);
        int cm = 0, cs = 0, ca = 0;
        for (int i = 0; i < 96; i++) begin @(negedge clk); drive(i); end
        for (int i = 0; i <= 48; i++) begin
            @(negedge clk);
            if (i > 0) begin cm += int'(main_en); cs += int'(sub_en); ca += int'(aux_en); end
            if (i < 48) drive(i); else quiet();
        end
        chk(cm, em, {tag, " main"});
        chk(cs, es, {tag, " sub"});
        chk(ca, ea, {tag, " aux"});
    endtask

    task automatic set_pw(input logic [3:0] b);
        @(negedge clk);
        {pw_gen1_off, pw_gen0_off, pw_osc_off, pw_cpu_off} = b;
    endtask

    task automatic t_reset();
        int ens = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); ens += int'(main_en) + int'(sub_en) + int'(aux_en);
        end
        chk(ens, 0, "R1 enables idle after reset");
        rd_chk(8'h56, 8'h60, "R1 osc reset");
        rd_chk(8'h57, 8'h87, "R1 sys1 reset");
        rd_chk(8'h58, 8'h00, "R1 sys2 reset");
        rd_chk(8'h53, 8'h05, "R1 auxc reset");
        rd_chk(8'h54, 8'h00, "R1 unmapped read");
    endtask

    task automatic t_regs();
        wr(8'h56, 8'h3C); rd_chk(8'h56, 8'h3C, "R2 osc write");
        wr(8'h53, 8'hA1); rd_chk(8'h53, 8'hA1, "R2 auxc write");
        wr(8'h55, 8'hFF); rd_chk(8'h55, 8'h00, "R2 unmapped write read");
        rd_chk(8'h58, 8'h00, "R2 unmapped write keeps sys2");
        rd_chk(8'h57, 8'h87, "R2 unmapped write keeps sys1");
    endtask

    task automatic t_main();
        wr(8'h58, 8'h00); measure(expc(1,1,1), 48, 8, "R3 R4 dco div1");
        wr(8'h58, 8'h50); measure(expc(1,2,1), 48, 8, "R3 R4 code01 dco div2");
        wr(8'h58, 8'hA0); measure(expc(2,4,1), 48, 8, "R3 R4 xt2 div4");
        wr(8'h58, 8'hF0); measure(expc(3,8,1), 48, 8, "R3 R4 vlo div8");
        wr(8'h58, 8'h00);
    endtask

    task automatic t_sub();
        wr(8'h58, 8'h02); measure(48, expc(1,2,1), 8, "R5 sub dco div2");
        wr(8'h58, 8'h0C); measure(48, expc(2,4,1), 8, "R5 sub xt2 div4");
        wr(8'h58, 8'h0E); measure(48, expc(2,8,1), 8, "R5 sub xt2 div8");
        wr(8'h58, 8'h00);
    endtask

    task automatic t_aux();
        wr(8'h57, 8'hB7); measure(48, 48, expc(6,8,1), "R6 aux div8");
        wr(8'h57, 8'h97); measure(48, 48, expc(6,2,1), "R6 aux div2");
        wr(8'h57, 8'h87);
    endtask

    task automatic t_modes();
        set_pw(4'b0000); measure(48, 48, 8, "R7 active");
        set_pw(4'b0001); measure(0, 48, 8, "R7 mode L0");
        set_pw(4'b0101); measure(0, 48, 8, "R8 mode L1");
        set_pw(4'b1001); measure(0, 0, 8, "R8 mode L2");
        set_pw(4'b1101); measure(0, 0, 8, "R8 mode L3");
        set_pw(4'b1111); measure(0, 0, 0, "R9 mode L4");
        set_pw(4'b0010); measure(0, 0, 0, "R9 unlisted 0010");
        set_pw(4'b0011); measure(0, 0, 0, "R9 unlisted 0011");
        set_pw(4'b0000); measure(48, 48, 8, "R7 back to active");
    endtask

    task automatic t_restart();
        @(negedge clk); dco_tick = 1'b1;
        wr(8'h58, 8'h20);
        chk(int'(main_en), 0, "R10 quiet after write edge");
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            chk(int'(main_en), (j == 4) ? 1 : 0, $sformatf("R10 div4 edge %0d", j));
        end
    endtask

    task automatic t_boundary();
        int cnt = 0, at8 = 0;
        @(negedge clk); dco_tick = 1'b1;
        wr(8'h58, 8'h30);
        for (int j = 1; j <= 30; j++) begin
            @(negedge clk);
            cnt += int'(main_en);
            if (j == 8) at8 = int'(main_en);
            if (j == 2) pw_cpu_off = 1'b1;
        end
        chk(cnt, 1, "R11 one pulse after mode change");
        chk(at8, 1, "R11 pulse at pending wrap");
        quiet();
        pw_cpu_off = 1'b0;
        wr(8'h58, 8'h00);
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_main();
        t_sub();
        t_aux();
        t_modes();
        t_restart();
        t_boundary();
        measure(48, 48, 8, "R11 active after boundary test");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule